// File: doc/BRIEF.md
# Readout Crate Event Word Receiver

This block sits in every readout crate and takes event words from the central event-number source. Each word is 16 bits wide. The low 12 bits hold a running event number and the high 4 bits hold an event type. The block holds `in_ready` high only while it is idle. When it accepts a word it stores the word and raises `busy` back toward the source. It also gives the local buffering logic a one-cycle start pulse. `busy` falls once that logic reports that the event is stored.

The captured word is decoded into two flags. One marks any special event, meaning a nonzero type. The other marks the synchronisation type, which is all ones. The block also checks that the event numbers arrive in order. It reports a source that presents a word while it is still busy.

The crate can start its own pedestal sequence. The block raises `busy` and asks local logic to switch off zero suppression. When the reconfiguration is confirmed, it drops `busy` and then fires a single-cycle pulser strobe.

The input word uses valid/ready flow control. The source presents `in_valid` with `in_data` and keeps both steady until `in_ready` is high at a rising edge. That edge is the transfer. `in_ready` is low whenever the block is not idle, which includes the two release cycles of the pedestal sequence. A source is expected to wait for `busy` to clear before it presents a word. A word presented during `busy` is treated as an overrun and is not taken.

Top module: `evt_rx_top`

## Requirements
- R1: `in_ready` is high only in the idle state. A word is taken at a rising edge where `in_valid` and `in_ready` are both high. From the following cycle, `evt_num` equals `in_data[11:0]` and `evt_type` equals `in_data[15:12]`.
- R2: In the cycle after a transfer, `busy` is high and `buf_start` is high for exactly that one cycle.
- R3: After a word is taken, `busy` stays high until `buf_done` is sampled high at a rising edge. `busy` is low from the next cycle, and `in_ready` is high again.
- R4: `is_special` is high when the captured type is not 4'b0000. `is_sync` is high when the captured type is 4'b1111.
- R5: `seq_err` is a one-cycle pulse that coincides with `buf_start`. It fires when the new event number is not the previous captured number plus one, modulo 4096. It never fires for the first word after reset.
- R6: `overrun_err` is high in any cycle where `in_valid` is high while `busy` is high. Such a word is not captured, so `evt_num` is unchanged.
- R7: A `pre_req` sampled in idle, with `in_valid` low, makes `busy` and `cfg_req` high from the next cycle. Both stay high until `cfg_done` is sampled high.
- R8: After `cfg_done`, `busy` is low for one cycle. Next, `pulser` is high for exactly one cycle with `busy` still low. The block then returns to idle. `in_ready` is low during both of these cycles.
- R9: In idle, a high `in_valid` takes priority over `pre_req`. The word is taken and `cfg_req` stays low.
- R10: After reset, `busy`, `buf_start`, `cfg_req`, `pulser`, `seq_err`, `evt_num` and `evt_type` are all zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Event word present |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 16 | Event word: type in [15:12], number in [11:0] |
| busy | output | 1 | Busy returned to the event source |
| buf_start | output | 1 | One-cycle request to buffer the event |
| buf_done | input | 1 | Local buffering finished |
| evt_num | output | 12 | Captured event number |
| evt_type | output | 4 | Captured event type |
| is_special | output | 1 | Captured type is nonzero |
| is_sync | output | 1 | Captured type is all ones |
| pre_req | input | 1 | Start the local pedestal sequence |
| cfg_req | output | 1 | Request to disable zero suppression |
| cfg_done | input | 1 | Zero suppression reconfigured |
| pulser | output | 1 | One-cycle pedestal pulser strobe |
| overrun_err | output | 1 | Word presented while busy |
| seq_err | output | 1 | Event number out of sequence |

## Verification
A corrupted state register shows up within one cycle. Either `busy` fails to rise after a transfer, or `in_ready` stays high while `busy` is high. In the pedestal sequence, a wrong state makes the pulser fire too early or not at all.

A corrupted event-number register is visible straight away on `evt_num`. It also produces a false `seq_err` on the very next word, and that pulse lines up with `buf_start`. The sweep covers all sixteen type codes, the wrap from 4095 to 0, and deliberate skips in the numbering.

// File: rtl/evt_rx_pkg.sv
package evt_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVT,
    ST_CFG,
    ST_REL,
    ST_FIRE
  } rx_state_e;
endpackage

// File: rtl/evt_rx_capture.sv
module evt_rx_capture #(
  parameter int NUM_W  = 12,
  parameter int TYPE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [NUM_W+TYPE_W-1:0] word,
  output logic [NUM_W-1:0]  num_q,
  output logic [TYPE_W-1:0] type_q,
  output logic              special,
  output logic              sync,
  output logic              seq_err
);
  localparam int WORD_W = NUM_W + TYPE_W;

  logic              seen_q;
  logic [NUM_W-1:0]  in_num;
  logic [TYPE_W-1:0] in_type;
  logic [NUM_W-1:0]  want_num;

  assign in_num   = word[NUM_W-1:0];
  assign in_type  = word[WORD_W-1:NUM_W];
  assign want_num = num_q + NUM_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q   <= '0;
      type_q  <= '0;
      seen_q  <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      seq_err <= take && seen_q && (in_num != want_num);
      if (take) begin
        num_q  <= in_num;
        type_q <= in_type;
        seen_q <= 1'b1;
      end
    end
  end

  assign special = |type_q;
  assign sync    = &type_q;
endmodule

// File: rtl/evt_rx_fsm.sv
module evt_rx_fsm
  import evt_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic pre_req,
  input  logic buf_done,
  input  logic cfg_done,
  output logic ready,
  output logic take,
  output logic busy,
  output logic buf_start,
  output logic cfg_req,
  output logic pulser,
  output logic overrun
);
  rx_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (in_valid)     st_d = ST_EVT;
        else if (pre_req) st_d = ST_CFG;
      end
      ST_EVT:  if (buf_done) st_d = ST_IDLE;
      ST_CFG:  if (cfg_done) st_d = ST_REL;
      ST_REL:  st_d = ST_FIRE;
      ST_FIRE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      buf_start <= 1'b0;
    end else begin
      st_q      <= st_d;
      buf_start <= take;
    end
  end

  assign ready   = (st_q == ST_IDLE);
  assign take    = ready && in_valid;
  assign busy    = (st_q == ST_EVT) || (st_q == ST_CFG);
  assign cfg_req = (st_q == ST_CFG);
  assign pulser  = (st_q == ST_FIRE);
  assign overrun = in_valid && busy;
endmodule

// File: rtl/evt_rx_top.sv
module evt_rx_top #(
  parameter int NUM_W  = 12,
  parameter int TYPE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NUM_W+TYPE_W-1:0] in_data,
  output logic                    busy,
  output logic                    buf_start,
  input  logic                    buf_done,
  output logic [NUM_W-1:0]        evt_num,
  output logic [TYPE_W-1:0]       evt_type,
  output logic                    is_special,
  output logic                    is_sync,
  input  logic                    pre_req,
  output logic                    cfg_req,
  input  logic                    cfg_done,
  output logic                    pulser,
  output logic                    overrun_err,
  output logic                    seq_err
);
  logic take;

  evt_rx_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pre_req   (pre_req),
    .buf_done  (buf_done),
    .cfg_done  (cfg_done),
    .ready     (in_ready),
    .take      (take),
    .busy      (busy),
    .buf_start (buf_start),
    .cfg_req   (cfg_req),
    .pulser    (pulser),
    .overrun   (overrun_err)
  );

  evt_rx_capture #(.NUM_W(NUM_W), .TYPE_W(TYPE_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .word    (in_data),
    .num_q   (evt_num),
    .type_q  (evt_type),
    .special (is_special),
    .sync    (is_sync),
    .seq_err (seq_err)
  );
endmodule

// File: rtl/evt_rx_chk.sv
module evt_rx_chk #(
  parameter int NUM_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             busy,
  input logic             buf_start,
  input logic             buf_done,
  input logic [NUM_W-1:0] evt_num,
  input logic             is_special,
  input logic             is_sync,
  input logic             cfg_req,
  input logic             pulser,
  input logic             overrun_err,
  input logic             seq_err
);
  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy); // R1
  AST_START_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && buf_start)); // R2
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_req && !buf_done) |=> busy); // R3
  AST_SYNC_IS_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
    is_sync |-> is_special); // R4
  AST_SEQ_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> buf_start); // R5
  AST_OVERRUN_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |=> $stable(evt_num)); // R6
  AST_CFG_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> busy); // R7
  AST_PULSE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pulser |-> (!busy && $past(!busy))); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulser |=> !pulser); // R8
endmodule

bind evt_rx_top evt_rx_chk #(.NUM_W(NUM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .busy        (busy),
  .buf_start   (buf_start),
  .buf_done    (buf_done),
  .evt_num     (evt_num),
  .is_special  (is_special),
  .is_sync     (is_sync),
  .cfg_req     (cfg_req),
  .pulser      (pulser),
  .overrun_err (overrun_err),
  .seq_err     (seq_err)
);

// File: tb/evt_rx_top_bench.sv
module evt_rx_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        busy, buf_start, buf_done = 1'b0;
  logic [11:0] evt_num;
  logic [3:0]  evt_type;
  logic        is_special, is_sync;
  logic        pre_req = 1'b0, cfg_req, cfg_done = 1'b0;
  logic        pulser, overrun_err, seq_err;

  int checks = 0;
  int errors = 0;
  int prev_num = 0;
  bit seen = 0;

  always #10 clk = ~clk;

  evt_rx_top u_evt_rx_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .busy(busy), .buf_start(buf_start), .buf_done(buf_done),
    .evt_num(evt_num), .evt_type(evt_type), .is_special(is_special),
    .is_sync(is_sync), .pre_req(pre_req), .cfg_req(cfg_req),
    .cfg_done(cfg_done), .pulser(pulser), .overrun_err(overrun_err),
    .seq_err(seq_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_evt(input int num, input int typ, input int hold);
    int exp_seq;
    exp_seq = (seen && (num != ((prev_num + 1) % 4096))) ? 1 : 0;
    @(negedge clk);
    chk("R1 ready idle", int'(in_ready), 1);
    in_valid = 1'b1;
    in_data  = {typ[3:0], num[11:0]};
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 busy", int'(busy), 1);
    chk("R2 buf_start", int'(buf_start), 1);
    chk("R1 evt_num", int'(evt_num), num);
    chk("R1 evt_type", int'(evt_type), typ);
    chk("R4 special", int'(is_special), (typ != 0) ? 1 : 0);
    chk("R4 sync", int'(is_sync), (typ == 15) ? 1 : 0);
    chk("R5 seq_err", int'(seq_err), exp_seq);
    prev_num = num;
    seen = 1;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R3 busy held", int'(busy), 1);
      chk("R2 start single", int'(buf_start), 0);
    end
    buf_done = 1'b1;
    @(negedge clk);
    buf_done = 1'b0;
    chk("R3 busy released", int'(busy), 0);
    chk("R3 ready back", int'(in_ready), 1);
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 busy", int'(busy), 0);
    chk("R10 ready", int'(in_ready), 1);
    chk("R10 start", int'(buf_start), 0);
    chk("R10 cfg", int'(cfg_req), 0);
    chk("R10 pulser", int'(pulser), 0);
    chk("R10 seq", int'(seq_err), 0);
    chk("R10 num", int'(evt_num), 0);
    chk("R10 type", int'(evt_type), 0);

    // R5: first word is never a sequence error, even though 4085 != 0+1
    begin
      int n;
      n = 4085;
      for (int i = 0; i < 40; i++) begin
        if (i == 12 || i == 27) n = (n + 2) % 4096;
        send_evt(n, i % 16, i % 4);
        n = (n + 1) % 4096;
      end
    end

    // R6: overrun while busy
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'h1000 | 16'((prev_num + 1) % 4096);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'hF0AA;
    #1;
    chk("R6 overrun", int'(overrun_err), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 not captured", int'(evt_num), (prev_num + 1) % 4096);
    chk("R6 type kept", int'(evt_type), 1);
    prev_num = (prev_num + 1) % 4096;
    buf_done = 1'b1;
    @(negedge clk);
    buf_done = 1'b0;
    chk("R3 release after overrun", int'(busy), 0);

    // R7/R8: pedestal sequence with several confirm delays
    for (int d = 0; d < 4; d++) begin
      @(negedge clk);
      pre_req = 1'b1;
      @(negedge clk);
      pre_req = 1'b0;
      chk("R7 busy", int'(busy), 1);
      chk("R7 cfg_req", int'(cfg_req), 1);
      chk("R7 not ready", int'(in_ready), 0);
      for (int k = 0; k < d; k++) begin
        @(negedge clk);
        chk("R7 cfg held", int'(cfg_req), 1);
        chk("R8 no early pulse", int'(pulser), 0);
      end
      cfg_done = 1'b1;
      @(negedge clk);
      cfg_done = 1'b0;
      chk("R8 release busy", int'(busy), 0);
      chk("R8 no pulse yet", int'(pulser), 0);
      chk("R8 ready low", int'(in_ready), 0);
      @(negedge clk);
      chk("R8 pulse", int'(pulser), 1);
      chk("R8 busy low", int'(busy), 0);
      chk("R8 ready low fire", int'(in_ready), 0);
      @(negedge clk);
      chk("R8 single pulse", int'(pulser), 0);
      chk("R8 idle", int'(in_ready), 1);
    end

    // R9: valid beats pre_req
    @(negedge clk);
    in_valid = 1'b1;
    pre_req  = 1'b1;
    in_data  = 16'h0000 | 16'((prev_num + 1) % 4096);
    @(negedge clk);
    in_valid = 1'b0;
    pre_req  = 1'b0;
    chk("R9 start", int'(buf_start), 1);
    chk("R9 no cfg", int'(cfg_req), 0);
    chk("R9 seq ok", int'(seq_err), 0);
    buf_done = 1'b1;
    @(negedge clk);
    buf_done = 1'b0;
    chk("R9 back idle", int'(in_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule